// File: doc/BRIEF.md
# Byte-Accessed Down Counter Channel

This block is a single 16-bit down-counting channel that a processor reaches through an 8-bit bus. Software first writes a command byte that picks how the count is moved across the bus (low byte alone, high byte alone, or low byte followed by high byte) and whether the count runs in plain binary or as four decimal decades. It then writes an initial count into a holding register. That value moves into the counting element on the first count enable after the last byte of the count has arrived. From then on, every count enable takes one off the count, and the count wraps when it passes zero.

The live count is read through an output view in the same byte format. A latch command freezes that view so that a two-byte read is coherent while counting continues. The view follows the count again once the frozen value has been read completely. A new initial count may be written at any time. Writing a count changes neither the format nor the number system, and the running count keeps going until the new value is transferred.

Top module: `bytecnt_channel`

## Requirements
- R1: After reset the format is low-then-high and binary, the count and the holding register are zero, nothing is latched and the count does not change on count enables.
- R2: A command byte is written with `reg_sel`=1. Bits [1:0] choose the access: 01 low byte only, 10 high byte only, 11 low byte then high byte. Bit 2 set selects BCD. Such a command clears the holding register, both byte pointers, any pending transfer and any latch, and stops counting until a new count is transferred. A command byte with any of bits [7:3] set is ignored.
- R3: A count byte (`reg_sel`=0) goes into the low or high half of the holding register as the format dictates. In low-then-high format the first byte after programming is the low byte. A single-byte format leaves the other half at zero.
- R4: The holding register moves into the count on the first `tick` cycle after the cycle in which the final byte was written. A `tick` in that same cycle still decrements the old count. Without `tick` the count holds.
- R5: In binary, each further `tick` subtracts one modulo 65536, so an initial count of 0 becomes 0xFFFF on the first decrement.
- R6: In BCD, each nibble is a decade and each `tick` subtracts one in decimal: 0x0100 becomes 0x0099, 0x0010 becomes 0x0009, and 0x0000 becomes 0x9999.
- R7: Writing a new count does not change the format. Until the transfer, the running count keeps decrementing, including between the two bytes of a two-byte write.
- R8: `rdata` shows, in the cycle `rd_stb` is high, the byte selected by the format and the read pointer (low byte first in two-byte format). A read with `reg_sel`=1 returns zero. The view follows the live count when nothing is latched.
- R9: A command with bits [1:0]=00 freezes the view at the current count. The view stays frozen until it has been read completely in the current format, then follows the count again.
- R10: A latch command issued while a frozen value is still unread is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one decrement per high cycle |
| wr_stb | input | 1 | Bus write strobe |
| rd_stb | input | 1 | Bus read strobe, advances the read pointer |
| reg_sel | input | 1 | 1 selects the command byte, 0 selects the count |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational from state |

## Verification
A write, a latch command and a count transfer all take effect at the rising edge that samples them. A transfer always waits for a `tick` edge that follows the edge where the last byte landed. A read byte appears on `rdata` in the same cycle as `rd_stb`, combinationally from the state left by the previous edge, and the pointer advances at the next edge. The bench drives and samples only at falling edges. At each one it compares `rdata` against a behavioural model that was updated at the preceding rising edge. Directed reads are taken one time unit after the strobe is raised, so each expected byte is that of the state before the next edge.

// File: rtl/bytecnt_pkg.sv
// Shared types for the byte-accessed counter channel.
package bytecnt_pkg;
    // Access format held from the last program command; 00 is the latch command.
    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    // Bit position of the BCD select inside a command byte.
    localparam int CMD_BCD_BIT = 2;
    // First reserved bit of a command byte; this and higher bits must be zero.
    localparam int CMD_RSV_LSB = 3;
endpackage

// File: rtl/bytecnt_host_if.sv
// Bus side of the channel: decodes command bytes, keeps the access format,
// the number system, the holding register and both byte pointers.
// Assumes at most one of wr_stb / rd_stb per cycle and a bus at least 4 bits wide.
module bytecnt_host_if #(
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     wr_stb,
    input  logic                     rd_stb,
    input  logic                     reg_sel,
    input  logic [CNT_W/2-1:0]       wdata,
    output bytecnt_pkg::acc_e        acc_q,
    output logic                     bcd_q,
    output logic [CNT_W-1:0]         cr_q,
    output logic                     load_pend,
    output logic                     prog,
    output logic                     latch_cmd,
    output logic                     rd_done,
    output logic                     wptr_q,
    output logic                     rptr_q
);
    import bytecnt_pkg::*;

    localparam int BYTE_W = CNT_W / 2;

    logic cmd_wr;
    logic cmd_ok;
    logic data_wr;
    logic data_rd;
    logic last_wr;

    // Decode strobes into command, count-write and count-read events.
    always_comb begin
        cmd_wr    = wr_stb && reg_sel;
        cmd_ok    = cmd_wr && (wdata[BYTE_W-1:CMD_RSV_LSB] == '0);
        prog      = cmd_ok && (wdata[1:0] != ACC_LATCH);
        latch_cmd = cmd_ok && (wdata[1:0] == ACC_LATCH);
        data_wr   = wr_stb && !reg_sel;
        data_rd   = rd_stb && !reg_sel;
        last_wr   = data_wr && ((acc_q != ACC_LOHI) || wptr_q);
        rd_done   = data_rd && ((acc_q != ACC_LOHI) || rptr_q);
    end

    // Format and number system, replaced only by a program command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= ACC_LOHI;
            bcd_q <= 1'b0;
        end else if (prog) begin
            acc_q <= acc_e'(wdata[1:0]);
            bcd_q <= wdata[CMD_BCD_BIT];
        end
    end

    // Holding register: cleared on programming, filled one byte per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q <= '0;
        end else if (prog) begin
            cr_q <= '0;
        end else if (data_wr) begin
            if ((acc_q == ACC_HI) || ((acc_q == ACC_LOHI) && wptr_q))
                cr_q[CNT_W-1:BYTE_W] <= wdata;
            else
                cr_q[BYTE_W-1:0] <= wdata;
        end
    end

    // Write byte pointer, toggling only in two-byte format.
    always_ff @(posedge clk) begin
        if (!rst_n || prog)
            wptr_q <= 1'b0;
        else if (data_wr && (acc_q == ACC_LOHI))
            wptr_q <= !wptr_q;
    end

    // Read byte pointer, toggling only in two-byte format.
    always_ff @(posedge clk) begin
        if (!rst_n || prog)
            rptr_q <= 1'b0;
        else if (data_rd && (acc_q == ACC_LOHI))
            rptr_q <= !rptr_q;
    end

    // Pending transfer: set by the final byte, consumed by the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n || prog)
            load_pend <= 1'b0;
        else if (last_wr)
            load_pend <= 1'b1;
        else if (tick)
            load_pend <= 1'b0;
    end
endmodule

// File: rtl/bytecnt_count_elem.sv
// Counting element: presettable synchronous down counter, binary or BCD.
// Assumes CNT_W is a multiple of 4; BCD mode treats each nibble as a decade.
module bytecnt_count_elem #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_pend,
    input  logic             prog,
    input  logic             bcd,
    input  logic [CNT_W-1:0] cr,
    output logic [CNT_W-1:0] ce_q,
    output logic             armed_q
);
    localparam int             DIGITS = CNT_W / 4;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0]  bin_next;
    logic [CNT_W-1:0]  bcd_next;
    logic [DIGITS-1:0] borrow;
    logic              load;

    assign load     = tick && load_pend && !prog;
    assign bin_next = ce_q - ONE;
    assign borrow[0] = 1'b1;

    // One decade per nibble; a borrow ripples upward through zero digits.
    for (genvar g = 0; g < DIGITS; g++) begin : g_dec
        logic [3:0] dig;
        assign dig = ce_q[4*g +: 4];
        assign bcd_next[4*g +: 4] = borrow[g] ? ((dig == 4'd0) ? 4'd9 : dig - 4'd1) : dig;
        if (g < DIGITS - 1) begin : g_chain
            assign borrow[g+1] = borrow[g] && (dig == 4'd0);
        end
    end

    // Counting is enabled by the first transfer and stopped by programming.
    always_ff @(posedge clk) begin
        if (!rst_n || prog)
            armed_q <= 1'b0;
        else if (load)
            armed_q <= 1'b1;
    end

    // Count register: transfer has priority over decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ce_q <= '0;
        else if (load)
            ce_q <= cr;
        else if (tick && armed_q && !prog)
            ce_q <= bcd ? bcd_next : bin_next;
    end
endmodule

// File: rtl/bytecnt_out_latch.sv
// Output view: follows the count, or holds a snapshot after a latch command
// until that snapshot has been read out in the current format.
module bytecnt_out_latch #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   ce,
    input  logic               latch_cmd,
    input  logic               rd_done,
    input  logic               prog,
    input  logic               rptr,
    input  logic               reg_sel,
    input  bytecnt_pkg::acc_e  acc,
    output logic [CNT_W-1:0]   hold_q,
    output logic               latched_q,
    output logic [CNT_W/2-1:0] rdata
);
    import bytecnt_pkg::*;

    localparam int BYTE_W = CNT_W / 2;

    logic [CNT_W-1:0] view;
    logic             pick_hi;

    // Snapshot state: program clears, complete read releases, latch captures once.
    always_ff @(posedge clk) begin
        if (!rst_n || prog) begin
            latched_q <= 1'b0;
            hold_q    <= '0;
        end else if (latched_q && rd_done) begin
            latched_q <= 1'b0;
        end else if (latch_cmd && !latched_q) begin
            latched_q <= 1'b1;
            hold_q    <= ce;
        end
    end

    // Byte selection by format and read pointer; command reads return zero.
    always_comb begin
        view    = latched_q ? hold_q : ce;
        pick_hi = (acc == ACC_HI) || ((acc == ACC_LOHI) && rptr);
        if (reg_sel)
            rdata = '0;
        else if (pick_hi)
            rdata = view[CNT_W-1:BYTE_W];
        else
            rdata = view[BYTE_W-1:0];
    end
endmodule

// File: rtl/bytecnt_channel.sv
// Top of the byte-accessed down counter channel: bus decode, counting
// element and output view. Assumes a single clock and tick as an enable.
module bytecnt_channel #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_stb,
    input  logic               rd_stb,
    input  logic               reg_sel,
    input  logic [CNT_W/2-1:0] wdata,
    output logic [CNT_W/2-1:0] rdata
);
    bytecnt_pkg::acc_e acc_q;
    logic             bcd_q;
    logic [CNT_W-1:0] cr_q;
    logic [CNT_W-1:0] ce_q;
    logic [CNT_W-1:0] hold_q;
    logic             load_pend;
    logic             prog;
    logic             latch_cmd;
    logic             rd_done;
    logic             wptr_q;
    logic             rptr_q;
    logic             armed_q;
    logic             latched_q;

    bytecnt_host_if #(.CNT_W(CNT_W)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .reg_sel   (reg_sel),
        .wdata     (wdata),
        .acc_q     (acc_q),
        .bcd_q     (bcd_q),
        .cr_q      (cr_q),
        .load_pend (load_pend),
        .prog      (prog),
        .latch_cmd (latch_cmd),
        .rd_done   (rd_done),
        .wptr_q    (wptr_q),
        .rptr_q    (rptr_q)
    );

    bytecnt_count_elem #(.CNT_W(CNT_W)) u_ce (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load_pend (load_pend),
        .prog      (prog),
        .bcd       (bcd_q),
        .cr        (cr_q),
        .ce_q      (ce_q),
        .armed_q   (armed_q)
    );

    bytecnt_out_latch #(.CNT_W(CNT_W)) u_ol (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce_q),
        .latch_cmd (latch_cmd),
        .rd_done   (rd_done),
        .prog      (prog),
        .rptr      (rptr_q),
        .reg_sel   (reg_sel),
        .acc       (acc_q),
        .hold_q    (hold_q),
        .latched_q (latched_q),
        .rdata     (rdata)
    );
endmodule

// File: rtl/bytecnt_chk.sv
// Property checker for the counter channel, bound to every instance.
module bytecnt_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             prog,
    input logic             load_pend,
    input logic             armed_q,
    input logic             bcd_q,
    input logic             latched_q,
    input logic             rd_done,
    input logic             wptr_q,
    input logic             rptr_q,
    input logic [CNT_W-1:0] cr_q,
    input logic [CNT_W-1:0] ce_q,
    input logic [CNT_W-1:0] hold_q
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R4
    ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ce_q));

    // R4
    ce_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && load_pend && !prog) |=> (ce_q == $past(cr_q)) && armed_q);

    // R5
    bin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && armed_q && !load_pend && !prog && !bcd_q) |=> ce_q == $past(ce_q) - ONE);

    // R2
    prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> (!wptr_q && !rptr_q && !latched_q && !load_pend && !armed_q));

    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_q && !rd_done && !prog) |=> (latched_q && $stable(hold_q)));
endmodule

bind bytecnt_channel bytecnt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .prog      (prog),
    .load_pend (load_pend),
    .armed_q   (armed_q),
    .bcd_q     (bcd_q),
    .latched_q (latched_q),
    .rd_done   (rd_done),
    .wptr_q    (wptr_q),
    .rptr_q    (rptr_q),
    .cr_q      (cr_q),
    .ce_q      (ce_q),
    .hold_q    (hold_q)
);

// File: tb/bytecnt_channel_tb_top.sv
module bytecnt_channel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_stb = 1'b0;
    logic       rd_stb = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // behavioural reference state
    int m_acc = 3, m_bcd = 0, m_cr = 0, m_ce = 0, m_armed = 0, m_pend = 0;
    int m_wptr = 0, m_rptr = 0, m_lat = 0, m_hold = 0;

    bytecnt_channel dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    function automatic int dec_bcd(int v);
        int d;
        d = ((v >> 12) & 15) * 1000 + ((v >> 8) & 15) * 100 + ((v >> 4) & 15) * 10 + (v & 15);
        d = (d == 0) ? 9999 : d - 1;
        return ((d / 1000) << 12) | (((d / 100) % 10) << 8) | (((d / 10) % 10) << 4) | (d % 10);
    endfunction

    function automatic int exp_rdata();
        int v;
        v = m_lat ? m_hold : m_ce;
        if (reg_sel) return 0;
        if (m_acc == 2 || (m_acc == 3 && m_rptr == 1)) return (v >> 8) & 255;
        return v & 255;
    endfunction

    // reference model advanced at every rising edge
    always @(posedge clk) begin
        int n_acc, n_bcd, n_cr, n_ce, n_armed, n_pend, n_wptr, n_rptr, n_lat, n_hold;
        int cmd_ok, prog, latch, last_wr, rd_done;
        if (!rst_n) begin
            m_acc = 3; m_bcd = 0; m_cr = 0; m_ce = 0; m_armed = 0; m_pend = 0;
            m_wptr = 0; m_rptr = 0; m_lat = 0; m_hold = 0;
        end else begin
            n_acc = m_acc; n_bcd = m_bcd; n_cr = m_cr; n_ce = m_ce; n_armed = m_armed;
            n_pend = m_pend; n_wptr = m_wptr; n_rptr = m_rptr; n_lat = m_lat; n_hold = m_hold;
            cmd_ok  = (wr_stb && reg_sel && (wdata >> 3) == 0) ? 1 : 0;
            prog    = (cmd_ok && (wdata & 3) != 0) ? 1 : 0;
            latch   = (cmd_ok && (wdata & 3) == 0) ? 1 : 0;
            last_wr = (wr_stb && !reg_sel && (m_acc != 3 || m_wptr == 1)) ? 1 : 0;
            rd_done = (rd_stb && !reg_sel && (m_acc != 3 || m_rptr == 1)) ? 1 : 0;
            if (wr_stb && !reg_sel) begin
                if (m_acc == 2 || (m_acc == 3 && m_wptr == 1)) n_cr = (m_cr & 255) | (int'(wdata) << 8);
                else n_cr = (m_cr & 65280) | int'(wdata);
                if (m_acc == 3) n_wptr = 1 - m_wptr;
            end
            if (rd_stb && !reg_sel && m_acc == 3) n_rptr = 1 - m_rptr;
            if (last_wr) n_pend = 1; else if (tick) n_pend = 0;
            if (tick && m_pend && !prog) begin
                n_ce = m_cr; n_armed = 1;
            end else if (tick && m_armed && !prog) begin
                n_ce = m_bcd ? dec_bcd(m_ce) : ((m_ce + 65535) & 65535);
            end
            if (m_lat && rd_done) n_lat = 0;
            else if (latch && !m_lat) begin n_lat = 1; n_hold = m_ce; end
            if (prog) begin
                n_acc = wdata & 3; n_bcd = (wdata >> 2) & 1; n_cr = 0; n_wptr = 0; n_rptr = 0;
                n_pend = 0; n_armed = 0; n_lat = 0; n_hold = 0;
            end
            m_acc = n_acc; m_bcd = n_bcd; m_cr = n_cr; m_ce = n_ce; m_armed = n_armed;
            m_pend = n_pend; m_wptr = n_wptr; m_rptr = n_rptr; m_lat = n_lat; m_hold = n_hold;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // one cycle: compare against the model at the falling edge, then drive
    task automatic cyc(bit t, bit w, bit r, bit s, logic [7:0] d);
        @(negedge clk);
        if (rst_n) check("R8 model", int'(rdata), exp_rdata());
        tick = t; wr_stb = w; rd_stb = r; reg_sel = s; wdata = d;
    endtask

    task automatic wcmd(logic [7:0] d); cyc(0, 1, 0, 1, d); endtask
    task automatic wdat(logic [7:0] d); cyc(0, 1, 0, 0, d); endtask
    task automatic tk(int n); for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 8'h00); endtask
    task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 8'h00); endtask
    task automatic rd_chk(string req, int exp);
        cyc(0, 0, 1, 0, 8'h00);
        #1 check(req, int'(rdata), exp);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        tk(2);
        rd_chk("R1 low", 8'h00); rd_chk("R1 high", 8'h00);
        // R2 R3 R4: two-byte binary load and transfer
        wcmd(8'h03); wdat(8'h34); wdat(8'h12); idle(2);
        rd_chk("R4 before tick low", 8'h00); rd_chk("R4 before tick high", 8'h00);
        tk(1);
        rd_chk("R3 low first", 8'h34); rd_chk("R3 high second", 8'h12);
        tk(3);
        rd_chk("R5 step low", 8'h31); rd_chk("R8 high", 8'h12);
        // R4: tick in the final-byte cycle decrements the old count
        wdat(8'h00); cyc(1, 1, 0, 0, 8'h20);
        rd_chk("R4 same cycle low", 8'h30); rd_chk("R4 same cycle high", 8'h12);
        tk(1);
        rd_chk("R4 transfer low", 8'h00); rd_chk("R4 transfer high", 8'h20);
        // R9 R10: latch, ignored second latch, release
        wcmd(8'h00); tk(5);
        rd_chk("R9 frozen low", 8'h00);
        wcmd(8'h00); tk(2);
        rd_chk("R10 frozen high", 8'h20);
        rd_chk("R9 released low", 8'hF9); rd_chk("R9 released high", 8'h1F);
        // R2: reserved bits make the command ignored
        wcmd(8'h41); tk(1);
        rd_chk("R2 reserved ignored low", 8'hF8); rd_chk("R2 reserved ignored high", 8'h1F);
        // R2: programming clears latch and stops counting
        wcmd(8'h00); tk(2); wcmd(8'h03); tk(3);
        rd_chk("R2 disarm low", 8'hF6); rd_chk("R2 disarm high", 8'h1F);
        // R3: high-only format zeroes the low half
        wdat(8'h34); wdat(8'h12); wcmd(8'h02); wdat(8'h07); tk(2);
        rd_chk("R3 high only", 8'h06); rd_chk("R3 high only repeat", 8'h06);
        // R5: zero count wraps in binary
        wcmd(8'h01); wdat(8'h00); tk(2);
        rd_chk("R5 low only wrap", 8'hFF);
        wcmd(8'h03); wdat(8'h00); wdat(8'h00); tk(2);
        rd_chk("R5 wrap low", 8'hFF); rd_chk("R5 wrap high", 8'hFF);
        // R6: BCD decades
        wcmd(8'h07); wdat(8'h00); wdat(8'h01); tk(2);
        rd_chk("R6 0100 low", 8'h99); rd_chk("R6 0100 high", 8'h00);
        wdat(8'h00); wdat(8'h00); tk(2);
        rd_chk("R6 wrap low", 8'h99); rd_chk("R6 wrap high", 8'h99);
        wdat(8'h10); wdat(8'h00); tk(2);
        rd_chk("R6 0010 low", 8'h09); rd_chk("R6 0010 high", 8'h00);
        // R7: reload mid-run keeps counting until transfer
        wcmd(8'h03); wdat(8'h00); wdat(8'h01); tk(5);
        wdat(8'h50); tk(1);
        rd_chk("R7 between bytes low", 8'hFB); rd_chk("R7 between bytes high", 8'h00);
        wdat(8'h00); tk(1);
        rd_chk("R7 reload low", 8'h50); rd_chk("R7 reload high", 8'h00);
        // R8: command address reads zero
        cyc(0, 0, 1, 1, 8'h00);
        #1 check("R8 command read", int'(rdata), 0);
        idle(2);
        report();
    end
endmodule